// File: doc/BRIEF.md
# DMA Channel Address and Count Sequencer

This block is the transfer engine of a single DMA channel. A start pulse captures a base address, a base count and a mode byte. From then on, each granted transfer cycle does three things: it presents a physical memory address built from the live page input and the 16-bit current address, it advances the current address by one, and it decrements the current count by one. When the count wraps from zero to all ones, the block flags terminal count for that transfer. It then either masks itself or, in auto-initialize mode, reloads its base values and stays armed.

The loaded count is one less than the number of transfers wanted. A build parameter picks a byte channel or a word channel. A byte channel maps the current address beneath the full page value, giving a 64K window. A word channel shifts the address left by one, ignores the low page bit and moves 16-bit units, giving a 128K-byte window. The address never carries into the page, so crossing a page boundary needs a new page value from outside. In cascade mode the block makes no addresses and only passes the request and grant handshake through.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is masked, the current count is 0, `residue` reads 1, and `dack` and `hrq` stay low whatever `dreq` and `grant` do.
- R2: A `start` pulse loads current address and count from `base_addr` and `base_cnt`, latches `mode` and unmasks the channel. In a non-cascade mode, `hrq` equals `dreq` while unmasked, and a transfer step (`dack` high) happens only in a cycle with the channel unmasked, `dreq` high, `grant` high and `start` low.
- R3: A loaded count N gives exactly N+1 transfer steps, so a count of 0 gives one step. `tc` is high for one cycle, together with `dack`, on the step where the current count is 0.
- R4: On a byte channel (`WORD_CHAN`=0), `phys_addr` is {page[7:0], current_address[15:0]}.
- R5: On a word channel (`WORD_CHAN`=1), `phys_addr` is {page[7:1], current_address[15:0], 1'b0}, and page bit 0 has no effect on it.
- R6: The current address advances by one per step and wraps from 0xFFFF to 0x0000 with no change to the page bits of `phys_addr`.
- R7: Mode bits 3:2 select the direction of a step: 01 raises `to_mem`, 10 raises `from_mem`, and 00 (verify) raises neither. Both strobes appear only together with `dack`.
- R8: With mode bit 4 clear, the channel masks itself at terminal count (`chan_masked` high), and further requests give no step until the next `start`.
- R9: With mode bit 4 set (auto-initialize), terminal count reloads the current address and count from the base values captured at `start`, and the channel stays unmasked.
- R10: `residue` equals the current count plus one, modulo 65536. It reads 0 after a completed transfer that is not auto-initialized.
- R11: In cascade mode (mode bits 7:6 = 11), `hrq` follows `dreq`, `dack` follows `grant`, and `tc`, `to_mem`, `from_mem` and `phys_addr` stay 0. The current address and count do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load base values and mode, unmask the channel |
| base_addr | input | CNT_W | Starting 16-bit address within the page |
| base_cnt | input | CNT_W | Transfer count minus one |
| page | input | PAGE_W | Upper physical address bits, applied live |
| mode | input | 8 | Mode byte: [7:6] kind, [4] auto-initialize, [3:2] direction |
| dreq | input | 1 | Device request |
| grant | input | 1 | Bus grant from the arbiter |
| hrq | output | 1 | Hold request toward the arbiter |
| dack | output | 1 | Transfer acknowledge; marks a step in non-cascade modes |
| tc | output | 1 | Terminal count, one cycle on the last step |
| to_mem | output | 1 | Step writes memory (device to memory) |
| from_mem | output | 1 | Step reads memory (memory to device) |
| chan_masked | output | 1 | Channel mask state |
| phys_addr | output | PAGE_W+CNT_W | Physical memory address of the current step |
| residue | output | CNT_W | Current count plus one |

## Verification
The bench targets the off-by-one in the count. A design that stopped when the count reached zero would lose the last transfer, and it would also make no transfer at all for a loaded 0. The bench also drives the address across 0xFFFF. A design that carried into the page would show the page bits changing, and on the word channel a design that kept page bit 0 would give an odd page and misplace the whole 128K window. The remaining checks cover the two behaviours at terminal count: a reload that forgot the base values, or a channel that failed to mask itself, would show up as wrong addresses or as extra acknowledges. The last checks cover cascade, where a design that still counted would change the residue.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    // Transfer kind held in mode bits 7:6
    typedef enum logic [1:0] {
        KIND_DEMAND  = 2'b00,
        KIND_SINGLE  = 2'b01,
        KIND_BLOCK   = 2'b10,
        KIND_CASCADE = 2'b11
    } xfer_kind_e;

    // Direction held in mode bits 3:2
    typedef enum logic [1:0] {
        DIR_VERIFY   = 2'b00,
        DIR_TO_MEM   = 2'b01,
        DIR_FROM_MEM = 2'b10,
        DIR_RESERVED = 2'b11
    } xfer_dir_e;

    localparam int unsigned MODE_W        = 8;
    localparam int unsigned MODE_AUTO_BIT = 4;

    typedef struct packed {
        logic cascade;
        logic autoinit;
        logic to_mem;
        logic from_mem;
    } mode_flags_t;

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
    import dma_seq_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_flags_t       flags
);
    xfer_kind_e kind;
    xfer_dir_e  dir;

    always_comb begin
        kind           = xfer_kind_e'(mode[7:6]);
        dir            = xfer_dir_e'(mode[3:2]);
        flags.cascade  = (kind == KIND_CASCADE);
        flags.autoinit = mode[MODE_AUTO_BIT];
        flags.to_mem   = (dir == DIR_TO_MEM);
        flags.from_mem = (dir == DIR_FROM_MEM);
    end
endmodule

// File: rtl/dma_cnt_step.sv
module dma_cnt_step #(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] cur_addr,
    input  logic [CNT_W-1:0] cur_cnt,
    output logic [CNT_W-1:0] addr_next,
    output logic [CNT_W-1:0] cnt_next,
    output logic             cnt_last
);
    // The address wraps inside its own width; it never carries into the page.
    always_comb begin
        addr_next = cur_addr + CNT_W'(1);
        cnt_next  = cur_cnt - CNT_W'(1);
        cnt_last  = (cur_cnt == '0);
    end
endmodule

// File: rtl/dma_phys_map.sv
module dma_phys_map #(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PAGE_W    = 8,
    parameter bit          WORD_CHAN = 1'b0
) (
    input  logic [PAGE_W-1:0]       page,
    input  logic [CNT_W-1:0]        cur_addr,
    output logic [PAGE_W+CNT_W-1:0] phys
);
    generate
        if (WORD_CHAN) begin : g_word
            // Word units: shift left by one; the low page bit is dropped.
            assign phys = {page[PAGE_W-1:1], cur_addr, 1'b0};
        end else begin : g_byte
            assign phys = {page, cur_addr};
        end
    endgenerate
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int unsigned CNT_W     = 16,
    parameter int unsigned PAGE_W    = 8,
    parameter bit          WORD_CHAN = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CNT_W-1:0]        base_addr,
    input  logic [CNT_W-1:0]        base_cnt,
    input  logic [PAGE_W-1:0]       page,
    input  logic [7:0]              mode,
    input  logic                    dreq,
    input  logic                    grant,
    output logic                    hrq,
    output logic                    dack,
    output logic                    tc,
    output logic                    to_mem,
    output logic                    from_mem,
    output logic                    chan_masked,
    output logic [PAGE_W+CNT_W-1:0] phys_addr,
    output logic [CNT_W-1:0]        residue
);
    localparam int unsigned PHYS_W = PAGE_W + CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0]  addr;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  base_addr;
        logic [CNT_W-1:0]  base_cnt;
        logic [MODE_W-1:0] mode;
        logic              mask;
    } seq_state_t;

    seq_state_t st_d, st_q;

    mode_flags_t       flags;
    logic [CNT_W-1:0]  addr_next;
    logic [CNT_W-1:0]  cnt_next;
    logic              cnt_last;
    logic [PHYS_W-1:0] phys_raw;
    logic              step;

    // Plain views of state for the bound checker
    logic              casc_w;
    logic              auto_w;
    logic [CNT_W-1:0]  cur_addr_w;
    logic [CNT_W-1:0]  cur_cnt_w;
    logic [CNT_W-1:0]  base_cnt_w;

    dma_mode_decode u_dec (
        .mode  (st_q.mode),
        .flags (flags)
    );

    dma_cnt_step #(.CNT_W(CNT_W)) u_cnt (
        .cur_addr  (st_q.addr),
        .cur_cnt   (st_q.cnt),
        .addr_next (addr_next),
        .cnt_next  (cnt_next),
        .cnt_last  (cnt_last)
    );

    dma_phys_map #(
        .CNT_W     (CNT_W),
        .PAGE_W    (PAGE_W),
        .WORD_CHAN (WORD_CHAN)
    ) u_map (
        .page     (page),
        .cur_addr (st_q.addr),
        .phys     (phys_raw)
    );

    always_comb begin
        step = !st_q.mask && !flags.cascade && dreq && grant && !start;
        st_d = st_q;
        if (start) begin
            st_d.addr      = base_addr;
            st_d.cnt       = base_cnt;
            st_d.base_addr = base_addr;
            st_d.base_cnt  = base_cnt;
            st_d.mode      = mode;
            st_d.mask      = 1'b0;
        end else if (step) begin
            if (cnt_last && flags.autoinit) begin
                st_d.addr = st_q.base_addr;
                st_d.cnt  = st_q.base_cnt;
            end else begin
                st_d.addr = addr_next;
                st_d.cnt  = cnt_next;
                st_d.mask = cnt_last;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.addr      <= '0;
            st_q.cnt       <= '0;
            st_q.base_addr <= '0;
            st_q.base_cnt  <= '0;
            st_q.mode      <= '0;
            st_q.mask      <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (flags.cascade) begin
            hrq       = dreq;
            dack      = grant;
            phys_addr = '0;
        end else begin
            hrq       = dreq && !st_q.mask;
            dack      = step;
            phys_addr = phys_raw;
        end
        tc          = step && cnt_last;
        to_mem      = step && flags.to_mem;
        from_mem    = step && flags.from_mem;
        chan_masked = st_q.mask;
        residue     = st_q.cnt + CNT_W'(1);
        casc_w      = flags.cascade;
        auto_w      = flags.autoinit;
        cur_addr_w  = st_q.addr;
        cur_cnt_w   = st_q.cnt;
        base_cnt_w  = st_q.base_cnt;
    end

endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dreq,
    input logic             grant,
    input logic             hrq,
    input logic             dack,
    input logic             tc,
    input logic             to_mem,
    input logic             from_mem,
    input logic             cascade,
    input logic             autoinit,
    input logic [CNT_W-1:0] cur_addr,
    input logic [CNT_W-1:0] cur_cnt,
    input logic [CNT_W-1:0] base_cnt_q
);
    assert_gated_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !cascade) |-> (dreq && grant && hrq));

    assert_tc_on_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> dack);

    assert_addr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && !cascade && !tc) |=> (cur_addr == CNT_W'($past(cur_addr) + 1'b1)));

    assert_dir_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (to_mem || from_mem) |-> (dack && $onehot0({to_mem, from_mem})));

    assert_stop_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && !autoinit) |=> !dack);

    assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tc && autoinit) |=> (cur_cnt == base_cnt_q));

    assert_cascade_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cascade |-> (!tc && !to_mem && !from_mem && hrq == dreq));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq       (dreq),
    .grant      (grant),
    .hrq        (hrq),
    .dack       (dack),
    .tc         (tc),
    .to_mem     (to_mem),
    .from_mem   (from_mem),
    .cascade    (casc_w),
    .autoinit   (auto_w),
    .cur_addr   (cur_addr_w),
    .cur_cnt    (cur_cnt_w),
    .base_cnt_q (base_cnt_w)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] base_addr = '0;
    logic [15:0] base_cnt = '0;
    logic [7:0]  page = '0;
    logic [7:0]  mode = '0;
    logic        dreq = 1'b0;
    logic        grant = 1'b0;
    logic        hrq, dack, tc, to_mem, from_mem, chan_masked;
    logic [23:0] phys_addr;
    logic [15:0] residue;
    logic        w_hrq, w_dack, w_tc, w_to_mem, w_from_mem, w_masked;
    logic [23:0] w_phys;
    logic [15:0] w_residue;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dma_chan_seq #(.WORD_CHAN(1'b0)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .base_cnt(base_cnt), .page(page), .mode(mode), .dreq(dreq), .grant(grant),
        .hrq(hrq), .dack(dack), .tc(tc), .to_mem(to_mem), .from_mem(from_mem),
        .chan_masked(chan_masked), .phys_addr(phys_addr), .residue(residue)
    );

    dma_chan_seq #(.WORD_CHAN(1'b1)) u_dut_w (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .base_cnt(base_cnt), .page(page), .mode(mode), .dreq(dreq), .grant(grant),
        .hrq(w_hrq), .dack(w_dack), .tc(w_tc), .to_mem(w_to_mem), .from_mem(w_from_mem),
        .chan_masked(w_masked), .phys_addr(w_phys), .residue(w_residue)
    );

    // {base_addr, base_cnt, page, mode, expected step count}
    localparam logic [55:0] VEC [4] = '{
        {16'h1234, 16'h0002, 8'h56, 8'h44, 8'd3},
        {16'hFFFE, 16'h0003, 8'h0A, 8'h48, 8'd4},
        {16'h0000, 16'h0000, 8'hFF, 8'h40, 8'd1},
        {16'h8000, 16'h0004, 8'h01, 8'h44, 8'd5}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic arm(input logic [15:0] a, input logic [15:0] c,
                       input logic [7:0] p, input logic [7:0] m);
        @(negedge clk);
        dreq = 1'b0; grant = 1'b0;
        base_addr = a; base_cnt = c; page = p; mode = m; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        #1;
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        dreq = 1'b1; grant = 1'b1;
        #1;
        // R1: reset state
        check(residue == 16'd1, "R1 residue", residue, 1);
        check(chan_masked == 1'b1, "R1 masked", chan_masked, 1);
        check(dack == 1'b0, "R1 dack", dack, 0);
        check(hrq == 1'b0, "R1 hrq", hrq, 0);

        // Vector table walk
        for (int v = 0; v < 4; v++) begin
            logic [15:0] a, c;
            logic [7:0]  p, m, n;
            {a, c, p, m, n} = VEC[v];
            arm(a, c, p, m);
            check(residue == 16'(c + 1), "R10 residue after load", residue, 16'(c + 1));
            dreq = 1'b1; grant = 1'b1;
            #1;
            for (int i = 0; i < int'(n); i++) begin
                logic [15:0] ea;
                ea = 16'(a + 16'(i));
                check(dack == 1'b1, "R2 step ack", dack, 1);
                check(tc == (i == int'(n) - 1), "R3 terminal count", tc, (i == int'(n) - 1));
                check(phys_addr == {p, ea}, "R4 byte phys", phys_addr, {p, ea});
                check(w_phys == {p[7:1], ea, 1'b0}, "R5 word phys", w_phys, {p[7:1], ea, 1'b0});
                check(to_mem == (m[3:2] == 2'b01), "R7 to_mem", to_mem, (m[3:2] == 2'b01));
                check(from_mem == (m[3:2] == 2'b10), "R7 from_mem", from_mem, (m[3:2] == 2'b10));
                @(negedge clk);
                #1;
            end
            check(dack == 1'b0, "R8 no step after end", dack, 0);
            check(chan_masked == 1'b1, "R8 masked at end", chan_masked, 1);
            check(residue == 16'd0, "R10 residue after end", residue, 0);
            dreq = 1'b0; grant = 1'b0;
        end

        // R2: request without grant makes no step
        arm(16'h0040, 16'h0005, 8'h03, 8'h44);
        dreq = 1'b1; grant = 1'b0;
        #1;
        check(hrq == 1'b1, "R2 hrq on request", hrq, 1);
        check(dack == 1'b0, "R2 no ack without grant", dack, 0);
        @(negedge clk); #1;
        check(residue == 16'd6, "R2 count held without grant", residue, 6);
        dreq = 1'b0; grant = 1'b1;
        #1;
        check(dack == 1'b0 && hrq == 1'b0, "R2 no ack without request", {dack, hrq}, 0);
        @(negedge clk); #1;
        check(residue == 16'd6, "R2 count held without request", residue, 6);
        grant = 1'b0;

        // R6: address wraps within the page
        arm(16'hFFFF, 16'h0001, 8'h0A, 8'h48);
        dreq = 1'b1; grant = 1'b1;
        #1;
        check(phys_addr == 24'h0AFFFF, "R6 before wrap", phys_addr, 24'h0AFFFF);
        @(negedge clk); #1;
        check(phys_addr == 24'h0A0000, "R6 after wrap", phys_addr, 24'h0A0000);
        check(tc == 1'b1, "R3 count 1 gives two steps", tc, 1);
        dreq = 1'b0; grant = 1'b0;

        // R9: auto-initialize reload
        arm(16'h0100, 16'h0001, 8'h02, 8'h54);
        dreq = 1'b1; grant = 1'b1;
        #1;
        for (int i = 0; i < 4; i++) begin
            check(dack == 1'b1, "R9 still armed", dack, 1);
            check(phys_addr == {8'h02, 16'h0100 + 16'(i % 2)}, "R9 reload address",
                  phys_addr, {8'h02, 16'h0100 + 16'(i % 2)});
            check(tc == (i % 2 == 1), "R9 tc each pass", tc, (i % 2 == 1));
            @(negedge clk); #1;
        end
        check(chan_masked == 1'b0, "R9 not masked", chan_masked, 0);
        check(residue == 16'd2, "R9 count reloaded", residue, 2);
        dreq = 1'b0; grant = 1'b0;

        // R5: word channel ignores page bit 0
        arm(16'h1234, 16'h0000, 8'h57, 8'h44);
        check(w_phys == 24'h562468, "R5 page bit0 ignored", w_phys, 24'h562468);
        page = 8'h56;
        #1;
        check(w_phys == 24'h562468, "R5 even page same", w_phys, 24'h562468);
        check(phys_addr == 24'h561234, "R4 byte uses full page", phys_addr, 24'h561234);

        // R11: cascade pass-through
        arm(16'h2000, 16'h0007, 8'h11, 8'hC0);
        dreq = 1'b1; grant = 1'b0;
        #1;
        check(hrq == 1'b1 && dack == 1'b0, "R11 request passes", {hrq, dack}, 2'b10);
        grant = 1'b1;
        #1;
        check(dack == 1'b1, "R11 grant passes", dack, 1);
        check(tc == 1'b0 && to_mem == 1'b0 && from_mem == 1'b0, "R11 no strobes",
              {tc, to_mem, from_mem}, 0);
        check(phys_addr == 24'h0, "R11 no address", phys_addr, 0);
        repeat (3) @(negedge clk);
        #1;
        check(residue == 16'd8, "R11 count unchanged", residue, 8);
        dreq = 1'b0;
        #1;
        check(hrq == 1'b0, "R11 request drop", hrq, 0);
        grant = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule